// File: doc/BRIEF.md
# Plug-Orientation Crossbar Sequencer

This block is the control state machine for a plug-orientation crossbar. It filters the raw attach and flip indications from the connector's configuration-channel detector, makes one orientation decision for each attach, and programs an external high-speed crossbar through a small register-write handshake. The lane profile is written first and the orientation after it. The crossbar enable is raised only when power has been good for a set time, a guard window after attach has elapsed, and both writes have been acknowledged. The hot-plug indication toward the host passes only after a second settle window that follows every enable and every profile change.

Power loss forces the fail-safe route at once: crossbar disabled, side-A select and no profile. The orientation is then decided again when power returns. Detach tears the route down in a fixed order over distinct cycles. A failed register write is retried a bounded number of times. After the last failure the block parks in the safe route until detach. A debug override pins the select and profile outputs to values given on input pins.

Top module: `omux_ctrl`

## Requirements
- R1: During reset, and from the cycle after power-good is seen low, `mux_en` and `hpd_out` are 0, `mux_sel` is 0 (side A) and `mux_mode` is 00, unless the override is active.
- R2: `mux_en` rises only after power-good has been high continuously for at least PG_DLY cycles, and always at least PG_DLY+GUARD cycles after power-good rises.
- R3: An attach or flip input must hold a new level for DEB_CYC cycles (after a two-flop synchronizer) before it is accepted. A shorter attach pulse causes no register write and no output change, and an accepted attach enables the crossbar no sooner than DEB_CYC+GUARD cycles after the raw attach edge.
- R4: The orientation (flip input: 0 = side A, 1 = side B) is latched once when the attach is accepted. Later flip changes do not alter `mux_sel` until detach.
- R5: After attach acceptance, no write and no enable occur for GUARD cycles. `hpd_out` is first released exactly GUARD cycles after `mux_en` rises.
- R6: Per attach, the profile is written first (`cfg_addr`=0, `cfg_data` = mode code) and the orientation second (`cfg_addr`=1, `cfg_data` = {0, flip}). `mux_mode` takes the new code on the profile acknowledge, and `mux_sel` and `mux_en` change together on the orientation acknowledge.
- R7: Mode codes are 00 none, 01 USB only, 10 USB with two DP lanes, 11 four DP lanes. A different request while settled causes exactly one profile write. `mux_en` and `mux_sel` stay unchanged, and `hpd_out` is held low until a fresh GUARD settle window ends.
- R8: A mode request that arrives inside the attach guard window is held, and the profile written at the end of the window is the newest request.
- R9: `hpd_out` follows `hpd_in` only in the settled state with the crossbar enabled. Otherwise it is 0.
- R10: When a write gets an error response, the block retries it. At most 1+MAX_RETRY attempts are made per write. After the last error the crossbar stays disabled with safe defaults and no further request is issued until detach.
- R11: On detach, `hpd_out` falls first, `mux_en` falls one cycle later, and `mux_sel`/`mux_mode` clear one cycle after that.
- R12: While `force_on` is 1, `mux_sel` equals `force_sel` and `mux_mode` equals `force_mode`. When it drops, the automatic values return.
- R13: A power-good drop clears the latched orientation. When power returns with the plug still attached, the current flip level is latched afresh before enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cc_attach | input | 1 | Raw attach indication from the detector |
| cc_flip | input | 1 | Raw orientation indication, 1 = side B |
| pwr_good | input | 1 | Crossbar supply good |
| mode_req | input | 2 | Requested lane profile code |
| hpd_in | input | 1 | Hot-plug indication from the connector side |
| force_on | input | 1 | Debug override enable |
| force_sel | input | 1 | Override select value |
| force_mode | input | 2 | Override profile value |
| cfg_ack | input | 1 | Write accepted response |
| cfg_err | input | 1 | Write failed response |
| mux_en | output | 1 | Crossbar enable |
| mux_sel | output | 1 | Crossbar orientation select |
| mux_mode | output | 2 | Applied lane profile |
| hpd_out | output | 1 | Gated hot-plug indication toward the host |
| cfg_req | output | 1 | Write request, held until a response |
| cfg_addr | output | 1 | Write target: 0 profile, 1 orientation |
| cfg_data | output | 2 | Write value |

## Verification
Two functions can meet in one cycle. A profile request can land while the attach guard is running, and it then has to wait for the window to close rather than start a write early. A flip-input change can also arrive while the crossbar is live and must not move the select. Both are provoked by driving `mode_req` and `cc_flip` in the middle of the guard window or of the settled state. They are judged by comparing the ordered stream of output changes with a queue of expected events, and by checking the logged write attempts (address, data and count).

// File: rtl/omux_pkg.sv
package omux_pkg;

    typedef enum logic [1:0] {
        MODE_NONE   = 2'b00,
        MODE_USB    = 2'b01,
        MODE_USB_DP = 2'b10,
        MODE_DP4    = 2'b11
    } omux_mode_e;

    typedef enum logic [3:0] {
        ST_OFF, ST_PGWAIT, ST_IDLE, ST_GUARD, ST_WMODE, ST_WSEL,
        ST_SETTLE, ST_ON, ST_SAFE, ST_DHPD, ST_DEN, ST_DCLR
    } omux_state_e;

    localparam logic CFG_ADDR_MODE   = 1'b0;
    localparam logic CFG_ADDR_ORIENT = 1'b1;

    typedef struct packed {
        logic       addr;
        logic [1:0] data;
    } omux_wr_t;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/omux_debounce.sv
module omux_debounce #(
    parameter int N       = 2,
    parameter int DEB_CYC = 50000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] filt
);
    localparam int CW = omux_pkg::cnt_width(DEB_CYC);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic          s1, s2, cand, level;
        logic [CW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1    <= 1'b0;
                s2    <= 1'b0;
                cand  <= 1'b0;
                level <= 1'b0;
                cnt   <= '0;
            end else begin
                s1 <= raw[g];
                s2 <= s1;
                if (s2 != cand) begin
                    cand <= s2;
                    cnt  <= '0;
                end else if (cnt != LAST) begin
                    cnt <= cnt + 1'b1;
                end else begin
                    level <= cand;
                end
            end
        end

        assign filt[g] = level;
    end

endmodule

// File: rtl/omux_cfg_link.sv
module omux_cfg_link
    import omux_pkg::*;
#(
    parameter int MAX_RETRY = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  omux_wr_t wr_in,
    input  logic     ack,
    input  logic     err,
    output logic     req,
    output omux_wr_t wr_out,
    output logic     done,
    output logic     fail
);
    localparam int TW = cnt_width(MAX_RETRY);
    localparam logic [TW-1:0] TRY_LAST = TW'(MAX_RETRY);

    logic          busy, gap;
    logic [TW-1:0] tries;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            gap    <= 1'b0;
            tries  <= '0;
            done   <= 1'b0;
            fail   <= 1'b0;
            wr_out <= '0;
        end else begin
            done <= 1'b0;
            fail <= 1'b0;
            if (start) begin
                wr_out <= wr_in;
                busy   <= 1'b1;
                gap    <= 1'b0;
                tries  <= '0;
            end else if (gap) begin
                gap  <= 1'b0;
                busy <= 1'b1;
            end else if (busy && ack) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else if (busy && err) begin
                busy <= 1'b0;
                if (tries == TRY_LAST) begin
                    fail <= 1'b1;
                end else begin
                    tries <= tries + 1'b1;
                    gap   <= 1'b1;
                end
            end
        end
    end

    assign req = busy;

endmodule

// File: rtl/omux_seq.sv
module omux_seq
    import omux_pkg::*;
#(
    parameter int PG_DLY = 25000,
    parameter int GUARD  = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pg,
    input  logic       att,
    input  logic       flip,
    input  logic [1:0] mode_req,
    input  logic       link_done,
    input  logic       link_fail,
    output logic       link_start,
    output omux_wr_t   link_wr,
    output logic       en,
    output logic       sel,
    output logic [1:0] mode,
    output logic       settled
);
    localparam int CMAX = (PG_DLY > GUARD) ? PG_DLY : GUARD;
    localparam int CW   = cnt_width(CMAX);
    localparam logic [CW-1:0] PG_LAST = CW'(PG_DLY - 1);
    localparam logic [CW-1:0] G_LAST  = CW'(GUARD - 1);

    omux_state_e   st;
    logic [CW-1:0] cnt;
    logic          orient, relink;
    logic [1:0]    pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_OFF;
            cnt        <= '0;
            orient     <= 1'b0;
            relink     <= 1'b0;
            pend       <= MODE_NONE;
            en         <= 1'b0;
            sel        <= 1'b0;
            mode       <= MODE_NONE;
            link_start <= 1'b0;
            link_wr    <= '0;
        end else begin
            link_start <= 1'b0;
            pend       <= mode_req;
            if (!pg) begin
                st     <= ST_OFF;
                cnt    <= '0;
                orient <= 1'b0;
                relink <= 1'b0;
                en     <= 1'b0;
                sel    <= 1'b0;
                mode   <= MODE_NONE;
            end else begin
                unique case (st)
                    ST_OFF: begin
                        cnt <= '0;
                        st  <= ST_PGWAIT;
                    end
                    ST_PGWAIT:
                        if (cnt == PG_LAST) st <= ST_IDLE;
                        else cnt <= cnt + 1'b1;
                    ST_IDLE:
                        if (att) begin
                            orient <= flip;
                            cnt    <= '0;
                            st     <= ST_GUARD;
                        end
                    ST_GUARD:
                        if (!att) st <= ST_DHPD;
                        else if (cnt == G_LAST) begin
                            link_start <= 1'b1;
                            link_wr    <= '{addr: CFG_ADDR_MODE, data: pend};
                            st         <= ST_WMODE;
                        end else cnt <= cnt + 1'b1;
                    ST_WMODE:
                        if (!att) st <= ST_DHPD;
                        else if (link_fail) begin
                            en   <= 1'b0;
                            sel  <= 1'b0;
                            mode <= MODE_NONE;
                            st   <= ST_SAFE;
                        end else if (link_done) begin
                            mode <= link_wr.data;
                            if (relink) begin
                                relink <= 1'b0;
                                cnt    <= '0;
                                st     <= ST_SETTLE;
                            end else begin
                                link_start <= 1'b1;
                                link_wr    <= '{addr: CFG_ADDR_ORIENT, data: {1'b0, orient}};
                                st         <= ST_WSEL;
                            end
                        end
                    ST_WSEL:
                        if (!att) st <= ST_DHPD;
                        else if (link_fail) begin
                            mode <= MODE_NONE;
                            st   <= ST_SAFE;
                        end else if (link_done) begin
                            sel <= orient;
                            en  <= 1'b1;
                            cnt <= '0;
                            st  <= ST_SETTLE;
                        end
                    ST_SETTLE:
                        if (!att) st <= ST_DHPD;
                        else if (cnt == G_LAST) st <= ST_ON;
                        else cnt <= cnt + 1'b1;
                    ST_ON:
                        if (!att) st <= ST_DHPD;
                        else if (pend != mode) begin
                            relink     <= 1'b1;
                            link_start <= 1'b1;
                            link_wr    <= '{addr: CFG_ADDR_MODE, data: pend};
                            st         <= ST_WMODE;
                        end
                    ST_SAFE:
                        if (!att) st <= ST_DHPD;
                    ST_DHPD: begin
                        en <= 1'b0;
                        st <= ST_DEN;
                    end
                    ST_DEN: begin
                        sel    <= 1'b0;
                        mode   <= MODE_NONE;
                        orient <= 1'b0;
                        relink <= 1'b0;
                        st     <= ST_DCLR;
                    end
                    ST_DCLR: st <= ST_IDLE;
                    default: st <= ST_OFF;
                endcase
            end
        end
    end

    assign settled = (st == ST_ON);

endmodule

// File: rtl/omux_ctrl.sv
module omux_ctrl
    import omux_pkg::*;
#(
    parameter int DEB_CYC   = 50000,
    parameter int GUARD     = 100000,
    parameter int PG_DLY    = 25000,
    parameter int MAX_RETRY = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cc_attach,
    input  logic       cc_flip,
    input  logic       pwr_good,
    input  logic [1:0] mode_req,
    input  logic       hpd_in,
    input  logic       force_on,
    input  logic       force_sel,
    input  logic [1:0] force_mode,
    input  logic       cfg_ack,
    input  logic       cfg_err,
    output logic       mux_en,
    output logic       mux_sel,
    output logic [1:0] mux_mode,
    output logic       hpd_out,
    output logic       cfg_req,
    output logic       cfg_addr,
    output logic [1:0] cfg_data
);
    logic [1:0] filt;
    logic       start, done, fail, sel_a, settled;
    logic [1:0] mode_a;
    omux_wr_t   wr_seq, wr_bus;

    omux_debounce #(.N(2), .DEB_CYC(DEB_CYC)) u_deb (
        .clk  (clk),
        .rst  (rst),
        .raw  ({cc_flip, cc_attach}),
        .filt (filt)
    );

    omux_seq #(.PG_DLY(PG_DLY), .GUARD(GUARD)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pg         (pwr_good),
        .att        (filt[0]),
        .flip       (filt[1]),
        .mode_req   (mode_req),
        .link_done  (done),
        .link_fail  (fail),
        .link_start (start),
        .link_wr    (wr_seq),
        .en         (mux_en),
        .sel        (sel_a),
        .mode       (mode_a),
        .settled    (settled)
    );

    omux_cfg_link #(.MAX_RETRY(MAX_RETRY)) u_link (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .wr_in  (wr_seq),
        .ack    (cfg_ack),
        .err    (cfg_err),
        .req    (cfg_req),
        .wr_out (wr_bus),
        .done   (done),
        .fail   (fail)
    );

    assign cfg_addr = wr_bus.addr;
    assign cfg_data = wr_bus.data;
    assign mux_sel  = force_on ? force_sel  : sel_a;
    assign mux_mode = force_on ? force_mode : mode_a;
    assign hpd_out  = hpd_in & settled & mux_en;

endmodule

// File: rtl/omux_ctrl_chk.sv
module omux_ctrl_chk #(
    parameter int PG_DLY = 25000
) (
    input logic       clk,
    input logic       rst,
    input logic       pwr_good,
    input logic       hpd_in,
    input logic       force_on,
    input logic       mux_en,
    input logic       mux_sel,
    input logic [1:0] mux_mode,
    input logic       hpd_out,
    input logic       cfg_req,
    input logic       cfg_addr
);
    localparam int PW = omux_pkg::cnt_width(PG_DLY);
    localparam logic [PW-1:0] PG_FULL = PW'(PG_DLY);

    logic [PW-1:0] pg_run;

    always_ff @(posedge clk) begin
        if (rst || !pwr_good) pg_run <= '0;
        else if (pg_run != PG_FULL) pg_run <= pg_run + 1'b1;
    end

    AST_SAFE_PG_LOW: assert property (@(posedge clk) disable iff (rst)
        $past(!pwr_good) |-> (!mux_en && !hpd_out &&
                              (force_on || (!mux_sel && mux_mode == 2'b00)))); // R1
    AST_EN_AFTER_PG: assert property (@(posedge clk) disable iff (rst)
        mux_en |-> (pg_run == PG_FULL)); // R2
    AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (mux_en && $past(mux_en) && !force_on && !$past(force_on)) |-> $stable(mux_sel)); // R4
    AST_EN_RISE_NO_HPD: assert property (@(posedge clk) disable iff (rst)
        $rose(mux_en) |-> !hpd_out); // R5
    AST_PROFILE_ONLY_LIVE: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && mux_en) |-> (cfg_addr == 1'b0)); // R7
    AST_HPD_GATED: assert property (@(posedge clk) disable iff (rst)
        hpd_out |-> (mux_en && hpd_in)); // R9
    AST_DETACH_ORDER: assert property (@(posedge clk) disable iff (rst)
        ($fell(mux_en) && pwr_good && $past(pwr_good)) |-> $past(!hpd_out)); // R11

endmodule

bind omux_ctrl omux_ctrl_chk #(.PG_DLY(PG_DLY)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwr_good (pwr_good),
    .hpd_in   (hpd_in),
    .force_on (force_on),
    .mux_en   (mux_en),
    .mux_sel  (mux_sel),
    .mux_mode (mux_mode),
    .hpd_out  (hpd_out),
    .cfg_req  (cfg_req),
    .cfg_addr (cfg_addr)
);

// File: tb/tb_omux_ctrl.sv
module tb_omux_ctrl;
    localparam int DEB   = 8;
    localparam int GUARD = 16;
    localparam int PGD   = 10;
    localparam int RETRY = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cc_attach = 1'b0, cc_flip = 1'b0, pwr_good = 1'b0, hpd_in = 1'b1;
    logic [1:0] mode_req = 2'b00, force_mode = 2'b00;
    logic force_on = 1'b0, force_sel = 1'b0;
    logic cfg_ack = 1'b0, cfg_err = 1'b0;
    logic mux_en, mux_sel, hpd_out, cfg_req, cfg_addr;
    logic [1:0] mux_mode, cfg_data;

    omux_ctrl #(.DEB_CYC(DEB), .GUARD(GUARD), .PG_DLY(PGD), .MAX_RETRY(RETRY)) dut (
        .clk(clk), .rst(rst), .cc_attach(cc_attach), .cc_flip(cc_flip),
        .pwr_good(pwr_good), .mode_req(mode_req), .hpd_in(hpd_in),
        .force_on(force_on), .force_sel(force_sel), .force_mode(force_mode),
        .cfg_ack(cfg_ack), .cfg_err(cfg_err), .mux_en(mux_en), .mux_sel(mux_sel),
        .mux_mode(mux_mode), .hpd_out(hpd_out), .cfg_req(cfg_req),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    string last_tag = "R1";

    // Scoreboard: expected output changes, {en, sel, mode[1:0], hpd}
    typedef struct {
        logic [4:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    int   ev_cyc[$];

    // Register-write target model with a log of every attempt
    int n_att = 0, fail_until = 0;
    logic       log_addr [0:63];
    logic [1:0] log_data [0:63];

    always @(negedge clk) begin
        if (rst) begin
            cfg_ack = 1'b0;
            cfg_err = 1'b0;
        end else if (cfg_ack || cfg_err) begin
            cfg_ack = 1'b0;
            cfg_err = 1'b0;
        end else if (cfg_req) begin
            if (n_att < 64) begin
                log_addr[n_att] = cfg_addr;
                log_data[n_att] = cfg_data;
            end
            if (n_att < fail_until) cfg_err = 1'b1;
            else cfg_ack = 1'b1;
            n_att = n_att + 1;
        end
    end

    logic [4:0] prev_out = 5'b0;
    always @(negedge clk) begin
        logic [4:0] cur;
        exp_t e;
        cur = {mux_en, mux_sel, mux_mode, hpd_out};
        if (rst) prev_out = cur;
        else if (cur !== prev_out) begin
            ev_cyc.push_back(cyc);
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL %s unexpected output change: actual %b expected %b", last_tag, cur, prev_out);
            end else begin
                e = exp_q.pop_front();
                if (cur !== e.val) begin
                    n_fail++;
                    $display("FAIL %s output event: actual %b expected %b", e.tag, cur, e.val);
                end
            end
            prev_out = cur;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_ev(input logic [4:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic drain(input string tag, input int maxc);
        for (int i = 0; i < maxc && exp_q.size() != 0; i++) step(1);
        step(2);
        check(exp_q.size() == 0, {tag, " pending events"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic detach(input logic sel_now, input logic [1:0] mode_now, input string tag);
        cc_attach = 1'b0;
        expect_ev({1'b1, sel_now, mode_now, 1'b0}, tag);
        expect_ev({1'b0, sel_now, mode_now, 1'b0}, tag);
        expect_ev(5'b00000, tag);
        drain(tag, 100);
    endtask

    initial begin
        int tp, ta, base, n;
        step(3);
        last_tag = "R1";
        check({mux_en, mux_sel, mux_mode, hpd_out, cfg_req} == 6'b0, "R1 reset outputs",
              int'({mux_en, mux_sel, mux_mode, hpd_out}), 0);
        rst = 1'b0;
        step(2);

        // R2/R5/R6: first attach, side B, USB with two DP lanes
        last_tag = "R6";
        pwr_good = 1'b1; cc_attach = 1'b1; cc_flip = 1'b1; mode_req = 2'b10;
        tp = cyc;
        expect_ev(5'b00100, "R6 profile before select");
        expect_ev(5'b11100, "R6 select with enable");
        expect_ev(5'b11101, "R5 hpd after settle");
        drain("R6", 300);
        n = ev_cyc.size();
        check(ev_cyc[n-2] - tp >= PGD + GUARD, "R2 enable delay after power-good", ev_cyc[n-2] - tp, PGD + GUARD);
        check(ev_cyc[n-1] - ev_cyc[n-2] == GUARD, "R5 hpd settle window", ev_cyc[n-1] - ev_cyc[n-2], GUARD);
        check(n_att == 2 && log_addr[0] == 1'b0 && log_data[0] == 2'b10, "R6 first write is profile",
              int'({log_addr[0], log_data[0]}), 2);
        check(log_addr[1] == 1'b1 && log_data[1] == 2'b01, "R6 second write is orientation",
              int'({log_addr[1], log_data[1]}), 5);

        // R9: hpd passes only while settled
        last_tag = "R9";
        hpd_in = 1'b0;
        expect_ev(5'b11100, "R9 hpd follows low");
        step(3);
        hpd_in = 1'b1;
        expect_ev(5'b11101, "R9 hpd follows high");
        drain("R9", 10);

        // R4: flip input changes while live are ignored
        last_tag = "R4";
        cc_flip = 1'b0;
        step(40);
        check(mux_sel == 1'b1, "R4 select locked", mux_sel, 1);
        check(n_att == 2, "R4 no write on flip change", n_att, 2);

        // R7: profile change while settled
        last_tag = "R7";
        mode_req = 2'b11;
        expect_ev(5'b11100, "R7 hpd dropped for change");
        expect_ev(5'b11110, "R7 new profile, select kept");
        expect_ev(5'b11111, "R7 hpd after new settle");
        drain("R7", 200);
        check(n_att == 3 && log_addr[2] == 1'b0 && log_data[2] == 2'b11, "R7 single profile write",
              n_att, 3);

        // R13/R1: power loss, then resume with flip now low
        last_tag = "R13";
        pwr_good = 1'b0;
        expect_ev(5'b00000, "R1 fail-safe on power loss");
        drain("R1", 10);
        step(5);
        check({mux_en, mux_sel, mux_mode, hpd_out} == 5'b0, "R1 held safe while power low",
              int'({mux_en, mux_sel, mux_mode, hpd_out}), 0);
        pwr_good = 1'b1;
        expect_ev(5'b00110, "R13 profile rewritten");
        expect_ev(5'b10110, "R13 relatched side A");
        expect_ev(5'b10111, "R13 hpd released");
        drain("R13", 300);
        check(log_data[4] == 2'b00 && log_addr[4] == 1'b1, "R13 orientation write uses new flip",
              int'(log_data[4]), 0);

        // R11: detach order
        last_tag = "R11";
        detach(1'b0, 2'b11, "R11 detach order");
        n = ev_cyc.size();
        check(ev_cyc[n-2] - ev_cyc[n-3] == 1, "R11 enable falls after hpd", ev_cyc[n-2] - ev_cyc[n-3], 1);
        check(ev_cyc[n-1] - ev_cyc[n-2] == 1, "R11 clear after enable", ev_cyc[n-1] - ev_cyc[n-2], 1);

        // R3: short attach pulse is rejected
        last_tag = "R3";
        base = n_att;
        cc_flip = 1'b1;
        cc_attach = 1'b1;
        step(DEB / 2);
        cc_attach = 1'b0;
        step(80);
        check(n_att == base && mux_en == 1'b0, "R3 short pulse ignored", n_att - base, 0);

        // R8: request arriving inside the guard window is queued
        last_tag = "R8";
        mode_req = 2'b01;
        cc_attach = 1'b1;
        ta = cyc;
        step(DEB + 8);
        mode_req = 2'b10;
        expect_ev(5'b00100, "R8 queued profile");
        expect_ev(5'b11100, "R8 enable");
        expect_ev(5'b11101, "R8 hpd");
        drain("R8", 300);
        n = ev_cyc.size();
        check(ev_cyc[n-2] - ta >= DEB + GUARD, "R3 attach-to-enable lower bound", ev_cyc[n-2] - ta, DEB + GUARD);
        check(n_att == base + 2 && log_data[base] == 2'b10, "R8 newest request written",
              int'(log_data[base]), 2);

        // R10: two errors, third attempt succeeds
        last_tag = "R10";
        detach(1'b1, 2'b10, "R11 detach before retry");
        base = n_att;
        fail_until = base + 2;
        cc_attach = 1'b1;
        expect_ev(5'b00100, "R10 profile after retries");
        expect_ev(5'b11100, "R10 enable after retries");
        expect_ev(5'b11101, "R10 hpd after retries");
        drain("R10", 400);
        check(n_att - base == 4 && log_addr[base+2] == 1'b0 && log_addr[base+3] == 1'b1,
              "R10 retry attempts", n_att - base, 4);

        // R10: all attempts fail, block parks safe
        detach(1'b1, 2'b10, "R11 detach before failure");
        base = n_att;
        fail_until = base + RETRY + 1;
        cc_attach = 1'b1;
        step(250);
        check(n_att - base == RETRY + 1, "R10 bounded attempts", n_att - base, RETRY + 1);
        check(mux_en == 1'b0 && cfg_req == 1'b0 && mux_mode == 2'b00, "R10 safe park",
              int'({mux_en, cfg_req, mux_mode}), 0);
        cc_attach = 1'b0;
        step(40);
        check(n_att - base == RETRY + 1, "R10 no request after park", n_att - base, RETRY + 1);

        // R12: override pins select and profile
        last_tag = "R12";
        force_sel = 1'b1; force_mode = 2'b11; force_on = 1'b1;
        expect_ev(5'b01110, "R12 override applied");
        drain("R12", 10);
        force_on = 1'b0;
        expect_ev(5'b00000, "R12 override released");
        drain("R12", 10);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog %s: actual timeout expected completion", last_tag);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule